// File: doc/BRIEF.md
# Streaming 3x3 Neighbourhood Window Generator

The block accepts an 8-bit pixel stream in raster order (left to right within a line, lines top to bottom), qualified by a row-sync input that is high while a line's active pixels are on the bus and a frame-sync input that is high only with the first pixel of a frame. Two inferred line memories and a three-column shift array assemble, for every pixel of the image, the 3x3 neighbourhood centred on it. A scan controller follows row and column position and flags window positions that fall outside the image. A pixel switch then fills those positions according to a static two-bit edge policy. A pass-through filter stage presents the centre pixel, and the output qualifiers are re-timed so they frame exactly the output beats.

Each output line is produced while the next input line streams in. The right-hand column of a line is finished in the first gap cycle after row-sync falls. The bottom image line is finished by an internally generated line that starts right after the last input line ends. Line width and frame height are parameters.

Top module: `nbr_win3x3`

## Requirements
- R1: For a centre (y,x) whose 3x3 neighbourhood lies fully inside the image, win_o holds the input pixel of row y-1+i, column x-1+j in bits [(i*3+j)*8 +: 8], i counting rows from the top (0..2) and j columns from the left (0..2).
- R2: pix_o equals the input pixel at the centre (y,x) of each output beat.
- R3: After reset rsync_o, fsync_o and valid_o are 0. Output line y (y < FRAME_H-1) has rsync_o high for LINE_W consecutive cycles, the first sampled two clocks after the edge that samples the first pixel of input line y+1. The last output line starts LINE_W+3 clocks after the edge sampling the first pixel of the last input line. The input must leave at least LINE_W+3 idle cycles after the last line, and at least one idle cycle between lines.
- R4: fsync_o is high for exactly one cycle per frame, on the beat of centre (0,0), and only while rsync_o is high.
- R5: With edge_mode_i = 0 (skip), valid_o is low on beats whose centre lies in the first or last row or column and high on all other beats; with any other mode valid_o is high on every beat.
- R6: With edge_mode_i = 1, every window position outside the image takes the centre pixel's value.
- R7: With edge_mode_i = 2, every window position outside the image is 0.
- R8: With edge_mode_i = 3, every window position outside the image is 255.
- R9: At the four image corners, the outside row and the outside column are both replaced, five positions in all.
- R10: A frame-sync restarts row counting, so a second frame sent after the first gives outputs that depend only on its own pixels.
- R11: Pixel values on pix_i while rsync_i is low are never written to the line memories and never appear in any output window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | High with the first pixel of a frame |
| rsync_i | input | 1 | High during the active pixels of a line |
| pix_i | input | DATA_W | Input pixel |
| edge_mode_i | input | 2 | Edge policy: 0 skip, 1 copy centre, 2 zero, 3 full scale |
| fsync_o | output | 1 | High on the beat of centre (0,0) |
| rsync_o | output | 1 | High on every output beat |
| valid_o | output | 1 | Beat carries a processed pixel under the edge policy |
| pix_o | output | DATA_W | Filter output (centre pixel) |
| win_o | output | 9*DATA_W | Switched 3x3 window, position (i,j) at bits (i*3+j)*DATA_W |

## Verification
Frames are built from a pixel value that changes with both row and column at distinct rates, so a window taken from the wrong line memory, shifted by a column, or mirrored shows a mismatch at every interior beat. The same frame shape is run under each of the four edge policies, which separates the replacement value at sides and corners from the raw neighbour data and separates skipped from processed border beats. Every line gap carries changing non-zero values on the pixel bus, which exposes any write or leakage outside row-sync. Two frames with different pixel seeds sent one after the other show whether position state and stale line contents are cleared by frame-sync.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

  localparam int WIN_N = 3;

  typedef enum logic [1:0] {
    EDGE_SKIP = 2'd0,
    EDGE_COPY = 2'd1,
    EDGE_ZERO = 2'd2,
    EDGE_FULL = 2'd3
  } edge_mode_e;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_ROW   = 2'd1,
    ST_FLUSH = 2'd2
  } scan_st_e;

  // window qualifier, aligned with the window registers
  typedef struct packed {
    logic vld;
    logic top;
    logic bot;
    logic lft;
    logic rgt;
  } win_tag_t;

endpackage

// File: rtl/nbr_line_buf.sv
module nbr_line_buf #(
  parameter int DEPTH  = 640,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= d_i;
  end

  // read-before-write: old line leaves while new line enters
  assign q_o = mem_q[addr_i];

  a_r11_wr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (int'(addr_i) < DEPTH));

endmodule

// File: rtl/nbr_scan_ctrl.sv
module nbr_scan_ctrl
  import nbr_pkg::*;
#(
  parameter int LINE_W  = 640,
  parameter int FRAME_H = 480,
  parameter int COL_W   = $clog2(LINE_W + 1),
  parameter int ROW_W   = $clog2(FRAME_H + 1),
  parameter int ADDR_W  = $clog2(LINE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              rsync_i,
  output logic              step_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output win_tag_t          tag_o
);

  scan_st_e         st_q;
  logic [COL_W-1:0] col_q, cur_col;
  logic [ROW_W-1:0] row_q, cur_row;
  logic             step;
  win_tag_t         tag_d;

  always_comb begin
    cur_col = col_q;
    cur_row = row_q;
    step    = 1'b0;
    unique case (st_q)
      ST_WAIT: begin
        step    = rsync_i;
        cur_col = '0;
        if (fsync_i) cur_row = '0;
      end
      ST_ROW, ST_FLUSH: step = 1'b1;
      default: step = 1'b0;
    endcase
  end

  assign step_o  = step;
  assign wr_en_o = rsync_i && (st_q != ST_FLUSH) && (cur_col < COL_W'(LINE_W));
  assign addr_o  = (cur_col < COL_W'(LINE_W)) ? ADDR_W'(cur_col) : '0;

  // window after this step is centred one row up and one column left
  always_comb begin
    tag_d.vld = step && (cur_row != '0) && (cur_col != '0);
    tag_d.top = (cur_row == ROW_W'(1));
    tag_d.bot = (cur_row == ROW_W'(FRAME_H));
    tag_d.lft = (cur_col == COL_W'(1));
    tag_d.rgt = (cur_col == COL_W'(LINE_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_WAIT;
      col_q <= '0;
      row_q <= '0;
      tag_o <= '0;
    end else begin
      tag_o <= tag_d;
      unique case (st_q)
        ST_WAIT: begin
          if (rsync_i) begin
            st_q  <= ST_ROW;
            col_q <= COL_W'(1);
            row_q <= cur_row;
          end
        end
        ST_ROW: begin
          if (rsync_i) begin
            if (col_q != COL_W'(LINE_W)) col_q <= col_q + COL_W'(1);
          end else begin
            // falling row-sync: closing step of the line, next row
            col_q <= '0;
            if (row_q < ROW_W'(FRAME_H)) row_q <= row_q + ROW_W'(1);
            st_q  <= (row_q == ROW_W'(FRAME_H - 1)) ? ST_FLUSH : ST_WAIT;
          end
        end
        ST_FLUSH: begin
          if (col_q == COL_W'(LINE_W)) begin
            col_q <= '0;
            st_q  <= ST_WAIT;
          end else begin
            col_q <= col_q + COL_W'(1);
          end
        end
        default: st_q <= ST_WAIT;
      endcase
    end
  end

  a_r3_col_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= COL_W'(LINE_W));

  a_r3_flush_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FLUSH && col_q != COL_W'(LINE_W)) |=> (st_q == ST_FLUSH));

  a_r10_row_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ROW && !rsync_i && row_q < ROW_W'(FRAME_H)) |=>
      (row_q == $past(row_q) + ROW_W'(1)));

endmodule

// File: rtl/nbr_window.sv
module nbr_window
  import nbr_pkg::*;
#(
  parameter int LINE_W = 640,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(LINE_W)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               step_i,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                  pix_i,
  output logic [WIN_N-1:0][WIN_N-1:0][DATA_W-1:0] win_o
);

  localparam int LB_N = WIN_N - 1;

  logic [DATA_W-1:0]            chain [LB_N+1];
  logic [WIN_N-1:0][DATA_W-1:0] new_col;
  logic [WIN_N-1:0][WIN_N-1:0][DATA_W-1:0] win_q;

  assign chain[0] = pix_i;

  for (genvar g = 0; g < LB_N; g++) begin : g_lb
    nbr_line_buf #(
      .DEPTH (LINE_W),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
    ) u_lb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_en_i),
      .addr_i(addr_i),
      .d_i   (chain[g]),
      .q_o   (chain[g+1])
    );
  end

  // oldest line on top, live pixel at the bottom
  for (genvar i = 0; i < WIN_N; i++) begin : g_col
    assign new_col[i] = chain[WIN_N-1-i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
    end else if (step_i) begin
      for (int i = 0; i < WIN_N; i++) begin
        for (int j = 0; j < WIN_N - 1; j++) win_q[i][j] <= win_q[i][j+1];
        win_q[i][WIN_N-1] <= new_col[i];
      end
    end
  end

  assign win_o = win_q;

endmodule

// File: rtl/nbr_pix_switch.sv
module nbr_pix_switch
  import nbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic [1:0]                              edge_mode_i,
  input  win_tag_t                                tag_i,
  input  logic [WIN_N-1:0][WIN_N-1:0][DATA_W-1:0] win_i,
  output logic                                    fsync_o,
  output logic                                    rsync_o,
  output logic                                    valid_o,
  output logic [DATA_W-1:0]                       pix_o,
  output logic [WIN_N-1:0][WIN_N-1:0][DATA_W-1:0] win_o
);

  edge_mode_e mode;
  logic       edge_any;
  logic       valid_d;
  logic [WIN_N-1:0][WIN_N-1:0][DATA_W-1:0] sw;

  assign mode     = edge_mode_e'(edge_mode_i);
  assign edge_any = tag_i.top | tag_i.bot | tag_i.lft | tag_i.rgt;
  assign valid_d  = tag_i.vld && !(mode == EDGE_SKIP && edge_any);

  always_comb begin
    for (int i = 0; i < WIN_N; i++) begin
      for (int j = 0; j < WIN_N; j++) begin
        logic outside;
        outside = (i == 0 && tag_i.top) || (i == WIN_N-1 && tag_i.bot) ||
                  (j == 0 && tag_i.lft) || (j == WIN_N-1 && tag_i.rgt);
        sw[i][j] = win_i[i][j];
        if (outside) begin
          unique case (mode)
            EDGE_COPY: sw[i][j] = win_i[1][1];
            EDGE_ZERO: sw[i][j] = '0;
            EDGE_FULL: sw[i][j] = '1;
            default:   sw[i][j] = win_i[i][j];
          endcase
        end
      end
    end
  end

  // output sync stage; filter is a centre pass-through
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsync_o <= 1'b0;
      rsync_o <= 1'b0;
      valid_o <= 1'b0;
      pix_o   <= '0;
      win_o   <= '0;
    end else begin
      fsync_o <= tag_i.vld && tag_i.top && tag_i.lft;
      rsync_o <= tag_i.vld;
      valid_o <= valid_d;
      pix_o   <= win_i[1][1];
      win_o   <= sw;
    end
  end

  a_r4_fsync_in_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> rsync_o);

  a_r4_fsync_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |=> !fsync_o);

  a_r5_valid_in_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> rsync_o);

  a_r2_centre_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsync_o |-> (win_o[1][1] == pix_o));

endmodule

// File: rtl/nbr_win3x3.sv
module nbr_win3x3
  import nbr_pkg::*;
#(
  parameter int LINE_W  = 640,
  parameter int FRAME_H = 480,
  parameter int DATA_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fsync_i,
  input  logic                      rsync_i,
  input  logic [DATA_W-1:0]         pix_i,
  input  logic [1:0]                edge_mode_i,
  output logic                      fsync_o,
  output logic                      rsync_o,
  output logic                      valid_o,
  output logic [DATA_W-1:0]         pix_o,
  output logic [WIN_N*WIN_N*DATA_W-1:0] win_o
);

  localparam int COL_W  = $clog2(LINE_W + 1);
  localparam int ROW_W  = $clog2(FRAME_H + 1);
  localparam int ADDR_W = $clog2(LINE_W);

  logic              step;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  win_tag_t          tag;
  logic [WIN_N-1:0][WIN_N-1:0][DATA_W-1:0] raw_win;
  logic [WIN_N-1:0][WIN_N-1:0][DATA_W-1:0] sw_win;

  nbr_scan_ctrl #(
    .LINE_W (LINE_W),
    .FRAME_H(FRAME_H),
    .COL_W  (COL_W),
    .ROW_W  (ROW_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fsync_i(fsync_i),
    .rsync_i(rsync_i),
    .step_o (step),
    .wr_en_o(wr_en),
    .addr_o (addr),
    .tag_o  (tag)
  );

  nbr_window #(
    .LINE_W(LINE_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .wr_en_i(wr_en),
    .addr_i (addr),
    .pix_i  (pix_i),
    .win_o  (raw_win)
  );

  nbr_pix_switch #(
    .DATA_W(DATA_W)
  ) u_sw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_mode_i(edge_mode_i),
    .tag_i      (tag),
    .win_i      (raw_win),
    .fsync_o    (fsync_o),
    .rsync_o    (rsync_o),
    .valid_o    (valid_o),
    .pix_o      (pix_o),
    .win_o      (sw_win)
  );

  assign win_o = sw_win;

endmodule

// File: tb/nbr_win3x3_tb_top.sv
module nbr_win3x3_tb_top;

  localparam int W   = 8;
  localparam int H   = 4;
  localparam int GAP = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fsync_i = 1'b0;
  logic        rsync_i = 1'b0;
  logic [7:0]  pix_i = '0;
  logic [1:0]  edge_mode = 2'd1;
  logic        fsync_o, rsync_o, valid_o;
  logic [7:0]  pix_o;
  logic [71:0] win_o;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int rise [H];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nbr_win3x3 #(.LINE_W(W), .FRAME_H(H), .DATA_W(8)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .fsync_i    (fsync_i),
    .rsync_i    (rsync_i),
    .pix_i      (pix_i),
    .edge_mode_i(edge_mode),
    .fsync_o    (fsync_o),
    .rsync_o    (rsync_o),
    .valid_o    (valid_o),
    .pix_o      (pix_o),
    .win_o      (win_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pv(input int seed, input int y, input int x);
    return 8'((seed + y * 37 + x * 11 + 1) & 255);
  endfunction

  function automatic logic [71:0] exp_win(input int seed, input int y, input int x,
                                          input logic [1:0] md);
    logic [71:0] r = '0;
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        int yy = y - 1 + i;
        int xx = x - 1 + j;
        logic [7:0] v;
        if (yy >= 0 && yy < H && xx >= 0 && xx < W) v = pv(seed, yy, xx);
        else if (md == 2'd1) v = pv(seed, y, x);
        else if (md == 2'd2) v = 8'd0;
        else v = 8'd255;
        r[(i*3+j)*8 +: 8] = v;
      end
    end
    return r;
  endfunction

  task automatic drive_frame(input int seed);
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        @(negedge clk);
        if (x == 0) rise[y] = cyc + 1;
        rsync_i = 1'b1;
        fsync_i = (y == 0 && x == 0);
        pix_i   = pv(seed, y, x);
      end
      for (int g = 0; g < GAP; g++) begin
        @(negedge clk);
        rsync_i = 1'b0;
        fsync_i = 1'b0;
        pix_i   = 8'hC3 ^ 8'(g * 29 + y * 5 + seed);  // R11 noise in gaps
      end
    end
    for (int g = 0; g < W + 8; g++) begin
      @(negedge clk);
      pix_i = 8'h5A ^ 8'(g * 17);
    end
  endtask

  task automatic monitor_frame(input int seed, input logic [1:0] md, input string itag);
    int cnt = 0;
    while (cnt < H * W) begin
      @(negedge clk);
      if (rsync_o) begin
        int  y = cnt / W;
        int  x = cnt % W;
        bit  border = (y == 0 || y == H - 1 || x == 0 || x == W - 1);
        bit  corner = (y == 0 || y == H - 1) && (x == 0 || x == W - 1);
        bit  exp_v  = (md != 2'd0) || !border;
        if (x == 0) begin
          int ec = (y < H - 1) ? rise[y+1] + 2 : rise[H-1] + W + 3;
          chk(cyc == ec, "R3", "row start cycle", 72'(cyc), 72'(ec));
        end
        chk(fsync_o == (y == 0 && x == 0), "R4", "fsync_o",
            72'(fsync_o), 72'(y == 0 && x == 0));
        chk(valid_o == exp_v, "R5", "valid_o", 72'(valid_o), 72'(exp_v));
        chk(pix_o == pv(seed, y, x), "R2", "pix_o", 72'(pix_o), 72'(pv(seed, y, x)));
        if (md != 2'd0 || !border) begin
          logic [71:0] ew = exp_win(seed, y, x, md);
          string t;
          if (!border) t = itag;
          else if (corner) t = "R9";
          else if (md == 2'd1) t = "R6";
          else if (md == 2'd2) t = "R7";
          else t = "R8";
          chk(win_o == ew, t, $sformatf("win_o y=%0d x=%0d", y, x), win_o, ew);
        end
        cnt++;
      end
    end
  endtask

  task automatic run_frame(input int seed, input logic [1:0] md, input string itag);
    @(negedge clk);
    edge_mode = md;
    fork
      drive_frame(seed);
      monitor_frame(seed, md, itag);
    join
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(rsync_o == 1'b0, "R3", "rsync_o in reset", 72'(rsync_o), 72'(0));
    chk(fsync_o == 1'b0, "R3", "fsync_o in reset", 72'(fsync_o), 72'(0));
    chk(valid_o == 1'b0, "R3", "valid_o in reset", 72'(valid_o), 72'(0));
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(rsync_o == 1'b0, "R3", "rsync_o idle", 72'(rsync_o), 72'(0));
  endtask

  task automatic t_copy();      run_frame(3,  2'd1, "R1");  endtask
  task automatic t_skip();      run_frame(40, 2'd0, "R1");  endtask
  task automatic t_zero();      run_frame(91, 2'd2, "R11"); endtask
  task automatic t_full();      run_frame(17, 2'd3, "R1");  endtask

  task automatic t_back_to_back();
    run_frame(120, 2'd1, "R10");
    run_frame(201, 2'd1, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_copy();
    t_skip();
    t_zero();
    t_full();
    t_back_to_back();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule